// File: doc/BRIEF.md
# Stereo Digital Volume With Staged Update

This block scales a stereo stream of signed 24-bit audio samples by a separate gain for each channel. It takes a logarithmic 8-bit volume code per channel and applies it in a two-stage pipeline. The first stage multiplies the sample by a linear gain derived from the code. The second stage rounds the product, saturates it to the signed 24-bit range and registers it at the output.

Volume codes arrive through a small register write port. The port has an address, a 9-bit data word and a write strobe. Each write lands in a staging register. The gain used by the datapath (the active code) changes only when a write carries the commit bit. That bit copies both channels' staging codes into the active registers on the same edge, so software can change left and right together without an audible step between them.

The gain law is 0.375 dB per code step, with 0 dB at code 0xC0. Code 0 mutes the channel. Every code above 239 gives the top gain of +17.625 dB. Each channel also has an enable input that silences it and suppresses its valid strobe.

Top module: `stereo_vol_stage`

## Requirements
- R1: After reset, both staging and active codes are 0xC0 (unity gain), both outputs are zero and neither output-valid is high.
- R2: For active codes 1 to 239 the output equals the input times 2^((code-192)/16), rounded to the nearest integer. The result is within 1 LSB plus 2^-15 of its magnitude.
- R3: Active code 0 produces an output of exactly 0 with output-valid still raised.
- R4: Active codes 239 to 255 all give the same gain as code 239 (+17.625 dB).
- R5: A result above 8388607 is output as 8388607 (0x7FFFFF), and a result below -8388608 is output as -8388608 (0x800000). The output never wraps.
- R6: A write whose data bit 8 is 0, to address 0x0F (left) or 0x10 (right), changes only that channel's staging code. The active gain of both channels stays unchanged.
- R7: A write to 0x0F or 0x10 with data bit 8 set copies both staging codes into the active registers on the same edge. The code carried by that write is included in the copy.
- R8: While a channel's enable is low, its output is zero and its output-valid stays low.
- R9: The read port returns {1'b0, staging code} for address 0x0F (left) and 0x10 (right), and 0 for any other address. Bit 8 always reads as 0.
- R10: A sample accepted on the edge where in_valid is high appears on the output with output-valid one edge later. A sample accepted on the same edge as a commit uses the gain that was active before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 9 | Bit 8 commit, bits 7:0 volume code |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 9 | Staging code readback, bit 8 always 0 |
| in_valid | input | 1 | Sample pair valid |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| en_left | input | 1 | Left channel enable |
| en_right | input | 1 | Right channel enable |
| out_valid_left | output | 1 | Left result valid |
| out_left | output | 24 | Left result, signed |
| out_valid_right | output | 1 | Right result valid |
| out_right | output | 24 | Right result, signed |

## Verification
A commit write and a sample strobe can land on the same clock edge. The bench provokes this by asserting wr_en with bit 8 set in the very cycle that in_valid is high. Its scoreboard records the expected result for that sample using the gain active before the write. The result of the next sample is expected with the newly committed gain, and any result that follows the new gain one sample early is counted as a mismatch.

// File: rtl/stvol_pkg.sv
package stvol_pkg;

    localparam int MANT_W = 17;   // unsigned mantissa, 16 fractional bits
    localparam int FRAC_W = 16;

    // 2^(k/16) in Q1.16, one 6 dB octave split into sixteen 0.375 dB steps
    function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] k);
        logic [MANT_W-1:0] m;
        unique case (k)
            4'd0:  m = 17'd65536;
            4'd1:  m = 17'd68438;
            4'd2:  m = 17'd71468;
            4'd3:  m = 17'd74632;
            4'd4:  m = 17'd77936;
            4'd5:  m = 17'd81386;
            4'd6:  m = 17'd84990;
            4'd7:  m = 17'd88752;
            4'd8:  m = 17'd92682;
            4'd9:  m = 17'd96785;
            4'd10: m = 17'd101070;
            4'd11: m = 17'd105545;
            4'd12: m = 17'd110218;
            4'd13: m = 17'd115097;
            4'd14: m = 17'd120193;
            default: m = 17'd125515;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stvol_regs.sv
module stvol_regs #(
    parameter int CW         = 8,
    parameter int AW         = 8,
    parameter logic [AW-1:0] LEFT_ADDR  = 8'h0F,
    parameter logic [AW-1:0] RIGHT_ADDR = 8'h10,
    parameter logic [CW-1:0] RESET_CODE = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW:0]   wr_data,
    output logic [CW-1:0] stage_l,
    output logic [CW-1:0] stage_r,
    output logic [CW-1:0] act_l,
    output logic [CW-1:0] act_r
);
    logic          hit_l, hit_r, commit;
    logic [CW-1:0] nxt_l, nxt_r;

    always_comb begin
        hit_l  = wr_en && (wr_addr == LEFT_ADDR);
        hit_r  = wr_en && (wr_addr == RIGHT_ADDR);
        nxt_l  = hit_l ? wr_data[CW-1:0] : stage_l;
        nxt_r  = hit_r ? wr_data[CW-1:0] : stage_r;
        commit = (hit_l || hit_r) && wr_data[CW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_l <= RESET_CODE;
            stage_r <= RESET_CODE;
            act_l   <= RESET_CODE;
            act_r   <= RESET_CODE;
        end else begin
            stage_l <= nxt_l;
            stage_r <= nxt_r;
            if (commit) begin
                act_l <= nxt_l;
                act_r <= nxt_r;
            end
        end
    end
endmodule

// File: rtl/stvol_code_map.sv
module stvol_code_map
    import stvol_pkg::*;
#(
    parameter int CW       = 8,
    parameter int TOP_CODE = 239
) (
    input  logic [CW-1:0]     code,
    output logic              mute,
    output logic [MANT_W-1:0] mant,
    output logic [CW-5:0]     oct
);
    localparam logic [CW-1:0] TOP = CW'(TOP_CODE);
    logic [CW-1:0] clamped;

    always_comb begin
        clamped = (code > TOP) ? TOP : code;
        mute    = (code == '0);
        mant    = mant_of(clamped[3:0]);
        oct     = clamped[CW-1:4];
    end
endmodule

// File: rtl/stvol_chan.sv
module stvol_chan
    import stvol_pkg::*;
#(
    parameter int DW         = 24,
    parameter int CW         = 8,
    parameter int TOP_CODE   = 239,
    parameter int UNITY_CODE = 192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] sample,
    input  logic [CW-1:0]        code,
    output logic                 out_vld,
    output logic signed [DW-1:0] out
);
    localparam int PW      = DW + MANT_W + 1;
    localparam int OCT_MAX = TOP_CODE / 16;
    localparam int SHW     = PW + OCT_MAX;
    localparam int SHIFT   = FRAC_W + UNITY_CODE / 16;
    localparam logic signed [SHW-1:0] RND = SHW'(1) <<< (SHIFT - 1);
    localparam logic signed [SHW-1:0] POS = (SHW'(1) <<< (DW - 1)) - SHW'(1);
    localparam logic signed [SHW-1:0] NEG = ~POS;

    logic                 mute_c, mute1, vld1;
    logic [MANT_W-1:0]    mant_c;
    logic [CW-5:0]        oct_c, oct1;
    logic signed [PW-1:0] p1;
    logic signed [SHW-1:0] shifted, rounded;
    logic signed [DW-1:0] sat;

    stvol_code_map #(.CW(CW), .TOP_CODE(TOP_CODE)) u_map (
        .code(code), .mute(mute_c), .mant(mant_c), .oct(oct_c)
    );

    // stage 1: multiply by the mantissa, hold shift and mute with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1    <= '0;
            oct1  <= '0;
            mute1 <= 1'b0;
            vld1  <= 1'b0;
        end else begin
            vld1 <= in_vld && en;
            if (in_vld) begin
                p1    <= sample * $signed({1'b0, mant_c});
                oct1  <= oct_c;
                mute1 <= mute_c;
            end
        end
    end

    always_comb begin
        shifted = {{OCT_MAX{p1[PW-1]}}, p1} <<< oct1;
        rounded = (shifted + RND) >>> SHIFT;
        if (rounded > POS)      sat = POS[DW-1:0];
        else if (rounded < NEG) sat = NEG[DW-1:0];
        else                    sat = rounded[DW-1:0];
    end

    // stage 2: round, saturate, register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out     <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= vld1 && en;
            if (!en)       out <= '0;
            else if (vld1) out <= mute1 ? '0 : sat;
        end
    end
endmodule

// File: rtl/stereo_vol_stage.sv
module stereo_vol_stage #(
    parameter int DW         = 24,
    parameter int CW         = 8,
    parameter int AW         = 8,
    parameter int TOP_CODE   = 239,
    parameter int UNITY_CODE = 192,
    parameter logic [AW-1:0] LEFT_ADDR  = 8'h0F,
    parameter logic [AW-1:0] RIGHT_ADDR = 8'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CW:0]          wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [CW:0]          rd_data,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    input  logic                 en_left,
    input  logic                 en_right,
    output logic                 out_valid_left,
    output logic signed [DW-1:0] out_left,
    output logic                 out_valid_right,
    output logic signed [DW-1:0] out_right
);
    localparam int NCH = 2;

    logic [CW-1:0]        stage_l, stage_r, act_l, act_r;
    logic signed [DW-1:0] smp_a  [NCH];
    logic signed [DW-1:0] res_a  [NCH];
    logic [CW-1:0]        code_a [NCH];
    logic [NCH-1:0]       en_a, vld_a;

    stvol_regs #(
        .CW(CW), .AW(AW), .LEFT_ADDR(LEFT_ADDR), .RIGHT_ADDR(RIGHT_ADDR),
        .RESET_CODE(CW'(UNITY_CODE))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_l(stage_l), .stage_r(stage_r),
        .act_l(act_l), .act_r(act_r)
    );

    always_comb begin
        smp_a[0]  = in_left;
        smp_a[1]  = in_right;
        code_a[0] = act_l;
        code_a[1] = act_r;
        en_a      = {en_right, en_left};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        stvol_chan #(
            .DW(DW), .CW(CW), .TOP_CODE(TOP_CODE), .UNITY_CODE(UNITY_CODE)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_a[ch]), .in_vld(in_valid),
            .sample(smp_a[ch]), .code(code_a[ch]),
            .out_vld(vld_a[ch]), .out(res_a[ch])
        );
    end

    always_comb begin
        out_left        = res_a[0];
        out_right       = res_a[1];
        out_valid_left  = vld_a[0];
        out_valid_right = vld_a[1];
        if (rd_addr == LEFT_ADDR)       rd_data = {1'b0, stage_l};
        else if (rd_addr == RIGHT_ADDR) rd_data = {1'b0, stage_r};
        else                            rd_data = '0;
    end
endmodule

// File: rtl/stvol_chk.sv
module stvol_chk #(
    parameter int DW = 24,
    parameter int CW = 8,
    parameter int AW = 8,
    parameter logic [AW-1:0] LEFT_ADDR  = 8'h0F,
    parameter logic [AW-1:0] RIGHT_ADDR = 8'h10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [CW:0]   wr_data,
    input logic          in_valid,
    input logic          en_left,
    input logic          out_valid_left,
    input logic [DW-1:0] out_left,
    input logic [CW-1:0] stage_l,
    input logic [CW-1:0] stage_r,
    input logic [CW-1:0] act_l,
    input logic [CW-1:0] act_r
);
    logic cmt;
    assign cmt = wr_en && wr_data[CW] &&
                 (wr_addr == LEFT_ADDR || wr_addr == RIGHT_ADDR);

    assert_stage_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == LEFT_ADDR) |-> stage_l == $past(wr_data[CW-1:0]));

    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmt) |-> ($stable(act_l) && $stable(act_r)));

    assert_commit_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmt) |-> (act_l == stage_l && act_r == stage_r));

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_left) |-> (!out_valid_left && out_left == '0));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && en_left, 2) && $past(en_left)) |-> out_valid_left);
endmodule

bind stereo_vol_stage stvol_chk #(
    .DW(DW), .CW(CW), .AW(AW), .LEFT_ADDR(LEFT_ADDR), .RIGHT_ADDR(RIGHT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .en_left(en_left),
    .out_valid_left(out_valid_left), .out_left(out_left),
    .stage_l(stage_l), .stage_r(stage_r), .act_l(act_l), .act_r(act_r)
);

// File: tb/stereo_vol_stage_tb.sv
module stereo_vol_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LA = 8'h0F;
    localparam logic [7:0] RA = 8'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, in_valid = 1'b0, en_left = 1'b1, en_right = 1'b1;
    logic [7:0] wr_addr = '0, rd_addr = '0;
    logic [8:0] wr_data = '0, rd_data;
    logic signed [23:0] in_left = '0, in_right = '0, out_left, out_right;
    logic out_valid_left, out_valid_right;

    int n_chk = 0, n_bad = 0;
    int act_l = 192, act_r = 192, stg_l = 192, stg_r = 192;
    int    q_l[$], q_r[$];
    string t_l[$], t_r[$];
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stereo_vol_stage u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .en_left(en_left), .en_right(en_right),
        .out_valid_left(out_valid_left), .out_left(out_left),
        .out_valid_right(out_valid_right), .out_right(out_right)
    );

    function automatic int model(int x, int code);
        real g, y;
        int c;
        if (code == 0) return 0;
        c = (code > 239) ? 239 : code;
        g = 2.0 ** ((c - 192) / 16.0);
        y = $floor(x * g + 0.5);
        if (y > 8388607.0) return 8388607;
        if (y < -8388608.0) return -8388608;
        return int'(y);
    endfunction

    task automatic check(string tag, int act, int exp, real tol);
        real d;
        d = (act > exp) ? real'(act - exp) : real'(exp - act);
        n_chk++;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver tasks: called at a falling edge, return at the next falling edge
    task automatic send(int l, int r, string tag);
        in_valid = 1'b1;
        in_left  = 24'(l);
        in_right = 24'(r);
        if (en_left)  begin q_l.push_back(model(l, act_l)); t_l.push_back(tag); end
        if (en_right) begin q_r.push_back(model(r, act_r)); t_r.push_back(tag); end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_reg(logic [7:0] a, logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == LA) stg_l = int'(d[7:0]);
        if (a == RA) stg_r = int'(d[7:0]);
        if (d[8] && (a == LA || a == RA)) begin act_l = stg_l; act_r = stg_r; end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_both(int l, int r) ; // both channels, one commit
        put_reg(LA, {1'b0, 8'(l)});
        put_reg(RA, {1'b1, 8'(r)});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid_left) begin
                if (q_l.size() == 0) check("R8 unexpected left valid", 1, 0, 0.0);
                else begin : pop_l
                    int e;
                    string t;
                    e = q_l.pop_front(); t = t_l.pop_front();
                    check(t, int'(out_left), e, 1.0 + (e < 0 ? -e : e) / 32768.0);
                end
            end
            if (out_valid_right) begin
                if (q_r.size() == 0) check("R8 unexpected right valid", 1, 0, 0.0);
                else begin : pop_r
                    int e;
                    string t;
                    e = q_r.pop_front(); t = t_r.pop_front();
                    check(t, int'(out_right), e, 1.0 + (e < 0 ? -e : e) / 32768.0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 out_left", int'(out_left), 0, 0.0);
        check("R1 out_valid_right", int'(out_valid_right), 0, 0.0);
        rd_addr = LA; #1;
        check("R1 R9 left staging readback", int'(rd_data), 9'h0C0, 0.0);
        rd_addr = RA; #1;
        check("R1 R9 right staging readback", int'(rd_data), 9'h0C0, 0.0);
        rd_addr = 8'h11; #1;
        check("R9 other address reads zero", int'(rd_data), 0, 0.0);
        send(12345, -54321, "R1 unity gain");
        send(-8388608, 8388607, "R1 unity extremes");
        idle(3);

        // R2 gain law at several codes
        put_both(208, 176);
        send(1000001, -1000001, "R2 +6dB / -6dB");
        send(-3, 3, "R2 rounding small");
        put_both(1, 100);
        send(4194304, -4194304, "R2 code 1 / code 100");
        put_both(191, 193);
        send(7777777, -7777777, "R2 one step each side");
        put_both(224, 150);
        send(654321, 1234567, "R2 +12dB / code 150");
        idle(3);

        // R3 mute
        put_both(0, 192);
        send(8388607, 5, "R3 mute left");
        idle(3);

        // R4 top clamp, R5 saturation
        put_both(239, 255);
        send(100000, 100000, "R4 codes 239 and 255 equal");
        send(8388607, -8388608, "R5 saturation");
        send(2000000, -2000000, "R5 saturation mid");
        idle(3);

        // R6 staging only, R9 readback, R7 commit
        put_both(192, 192);
        put_reg(LA, {1'b0, 8'd208});
        rd_addr = LA; #1;
        check("R9 R6 staged code read back, bit 8 zero", int'(rd_data), 208, 0.0);
        send(300000, 300000, "R6 active gain unchanged");
        put_reg(RA, {1'b1, 8'd176});
        send(300000, 300000, "R7 both channels committed");
        idle(3);

        // R10 commit and sample in the same cycle
        wr_en = 1'b1; wr_addr = LA; wr_data = {1'b1, 8'd224};
        in_valid = 1'b1; in_left = 24'sd40000; in_right = 24'sd40000;
        q_l.push_back(model(40000, act_l)); t_l.push_back("R10 collision uses old gain");
        q_r.push_back(model(40000, act_r)); t_r.push_back("R10 collision uses old gain");
        stg_l = 224; act_l = stg_l; act_r = stg_r;
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        send(40000, 40000, "R10 next sample uses new gain");
        idle(3);

        // R8 channel enable
        en_left = 1'b0;
        send(500000, 500000, "R8 right still active");
        send(-500000, 7, "R8 right still active");
        idle(3);
        check("R8 left held at zero", int'(out_left), 0, 0.0);
        check("R8 left valid low", int'(out_valid_left), 0, 0.0);
        en_left = 1'b1;
        idle(3);

        check("R10 scoreboard drained", q_l.size() + q_r.size(), 0, 0.0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule